// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM built for full bus use. Read and write cycles can follow each other on consecutive clocks with no idle cycle between them. Address and control are registered on the rising clock edge. The data for a write is taken one active edge after its address. Read data flows straight from the array during the cycle after the address edge. Because of this timing, a read placed right behind a write already sees the written word.

The model uses a single clock, an active-low clock enable that freezes the whole device, three chip selects of mixed polarity, one write-enable line, and active-low byte-lane write strobes. An advance/load input either loads a fresh address or steps an internal two-bit burst counter. A strap input picks linear or interleaved burst order. The data bus is split into a write-data input and a read-data output, and a drive flag stands in for the bidirectional pad enable. The output enable is asynchronous. The data output is forced off during writes and deselects, whatever the output enable says.

Top module: `zt_sram`

## Requirements
- R1: After reset, `drive_o` is 0 and `rdata_o` is all zeros until a read is registered.
- R2: A load edge (`burst_adv_i`=0, `cke_ni`=0) starts an operation only when `sel_a_ni`=0, `sel_b_i`=1 and `sel_c_ni`=0. With any select inactive, no read is driven and no write reaches the array.
- R3: After an active edge that registers a read, `rdata_o` shows the word at the address registered on that edge, and `drive_o` is 1 while `oe_ni` is 0.
- R4: The data for a write registered on one active edge is taken from `wdata_i` on the next active edge. A read registered on that next edge to the same address returns the new data.
- R5: `lane_wr_ni[i]`=0 writes bits [i*LANE_W +: LANE_W], where each lane holds a byte and its parity bit. The strobes are sampled with the address. Lanes whose strobe is 1 keep their stored value.
- R6: After an active edge that registers a write or a deselect, `drive_o` is 0 even when `oe_ni` is 0.
- R7: While `oe_ni` is 1, `drive_o` is 0 and `rdata_o` is zero, with no clock edge needed.
- R8: An edge with `cke_ni`=1 is ignored. Outputs, the current operation, the burst position and any pending write all hold, and the select inputs do not deselect the device.
- R9: With `burst_ilv_i`=0, each advance edge gives address low bits (start + n) mod 4, and the upper bits stay fixed.
- R10: With `burst_ilv_i`=1, each advance edge gives address low bits start XOR n.
- R11: An advance edge continues the operation type of the burst and ignores `we_ni`. An advance edge while idle starts nothing.
- R12: A deselect ends a burst in progress, so later advance edges drive nothing. A write already registered still completes with the data present on the deselect edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| sel_a_ni | input | 1 | Chip select A, active low |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_ni | input | 1 | Chip select C, active low |
| burst_adv_i | input | 1 | 1 = step burst counter, 0 = load new address |
| we_ni | input | 1 | Write enable, active low (0 = write, 1 = read) |
| lane_wr_ni | input | LANES | Per-lane write strobes, active low |
| burst_ilv_i | input | 1 | Burst order strap: 1 = interleaved, 0 = linear |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driving |
| drive_o | output | 1 | Read data driven onto the bus |

## Verification
Back-to-back patterns alternate writes and reads on consecutive edges, including a read to the address written one edge earlier. These show whether write data is taken one edge late and whether the array is up to date in time. Partial-strobe and all-strobes-off writes, each followed at once by a read, separate correct lane merging from whole-word writes. Each select is dropped on its own and a clock-enable stall is placed in the middle of a pending write, which shows the decode and the hold behaviour. Four-beat bursts from a start address that is not aligned are run in both orders. A write burst with the write enable toggling during the advance beats, and a deselect in the middle of a burst, separate the two orderings and show how the burst continues and stops.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (ilv_i) low = base_q[CNT_W-1:0] ^ cnt_q;
    else       low = base_q[CNT_W-1:0] + cnt_q;
  end

  assign addr_o = {base_q[ADDR_W-1:CNT_W], low};

  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
  AST_BURST_HIGH_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> $stable(addr_o[ADDR_W-1:CNT_W])); // R10
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [LANES-1:0]        lane_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && lane_en_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end

  AST_WR_ADDR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !$isunknown(addr_i)); // R4
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_ni,
  input  logic                    sel_a_ni,
  input  logic                    sel_b_i,
  input  logic                    sel_c_ni,
  input  logic                    burst_adv_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        lane_wr_ni,
  input  logic                    burst_ilv_i,
  input  logic                    oe_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  op_e               op_q, op_d;
  logic [LANES-1:0]  lanes_q;
  logic              active, selected, load_new, step_go, wr_now;
  logic [ADDR_W-1:0] cur_addr;
  logic [WORD_W-1:0] arr_rdata;

  assign active   = !cke_ni;
  assign selected = !sel_a_ni && sel_b_i && !sel_c_ni;
  assign load_new = active && !burst_adv_i && selected;
  assign step_go  = active && burst_adv_i && (op_q != OP_IDLE);
  // pending write commits with the data present on the following active edge
  assign wr_now   = active && (op_q == OP_WRITE);

  always_comb begin
    op_d = op_q;
    if (!burst_adv_i) begin
      if (!selected)   op_d = OP_IDLE;
      else if (we_ni)  op_d = OP_READ;
      else             op_d = OP_WRITE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      lanes_q <= '0;
    end else if (active) begin
      op_q <= op_d;
      if (load_new || step_go) lanes_q <= ~lane_wr_ni;
    end
  end

  zt_burst_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (2)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_new),
    .step_i (step_go),
    .ilv_i  (burst_ilv_i),
    .addr_i (addr_i),
    .addr_o (cur_addr)
  );

  zt_sram_array #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_now),
    .lane_en_i (lanes_q),
    .addr_i    (cur_addr),
    .wdata_i   (wdata_i),
    .rdata_o   (arr_rdata)
  );

  assign drive_o = (op_q == OP_READ) && !oe_ni;
  assign rdata_o = drive_o ? arr_rdata : '0;

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(op_q) && $stable(cur_addr))); // R8
  AST_DESEL_NO_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !burst_adv_i && !selected) |=> (op_q == OP_IDLE)); // R2
  AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !burst_adv_i && selected && !we_ni) |=> !drive_o); // R6
  AST_IDLE_ADV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && burst_adv_i && (op_q == OP_IDLE)) |=> !drive_o); // R11
endmodule

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int WW = LN * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_n = 1'b1, sa_n = 1'b1, sb = 1'b0, sc_n = 1'b1;
  logic adv = 1'b0, we_n = 1'b1, ilv = 1'b0, oe_n = 1'b0;
  logic [LN-1:0] lw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wd = '0;
  logic [WW-1:0] rd;
  logic drv;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_ni(cke_n),
    .sel_a_ni(sa_n), .sel_b_i(sb), .sel_c_ni(sc_n),
    .burst_adv_i(adv), .we_ni(we_n), .lane_wr_ni(lw_n),
    .burst_ilv_i(ilv), .oe_ni(oe_n), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rd), .drive_o(drv)
  );

  function automatic logic [WW-1:0] pat(input int k);
    logic [8:0] b;
    b = k[8:0];
    return {b ^ 9'h155, b, ~b, b ^ 9'h0AA};
  endfunction

  task automatic chk(input logic [WW-1:0] act, input logic [WW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step_ce(input bit cen, input bit a_n, input bit b, input bit c_n,
                         input bit ad, input bit w_n, input logic [LN-1:0] m_n,
                         input int a, input logic [WW-1:0] d);
    cke_n = cen; sa_n = a_n; sb = b; sc_n = c_n;
    adv = ad; we_n = w_n; lw_n = m_n; addr = a[AW-1:0]; wd = d;
    @(posedge clk);
    #1;
  endtask

  // selected, clock enabled
  task automatic step(input bit ad, input bit w_n, input logic [LN-1:0] m_n,
                      input int a, input logic [WW-1:0] d);
    step_ce(1'b0, 1'b0, 1'b1, 1'b0, ad, w_n, m_n, a, d);
  endtask

  task automatic desel(input logic [WW-1:0] d);
    step_ce(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 0, d);
  endtask

  task automatic prefill(input int base, input int n, input int seed);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, base + i, pat(seed + i - 1));
    desel(pat(seed + n - 1));
  endtask

  task automatic t_reset;
    chk(WW'(drv), WW'(0), "R1 drive after reset");
    chk(rd, '0, "R1 rdata after reset");
  endtask

  task automatic t_back2back;
    step(1'b0, 1'b0, '0, 5, '0);
    chk(WW'(drv), WW'(0), "R6 no drive after write edge");
    step(1'b0, 1'b1, '1, 5, pat(1));
    chk(rd, pat(1), "R4 read right after write");
    chk(WW'(drv), WW'(1), "R3 drive on read");
    step(1'b0, 1'b0, '0, 6, '0);
    chk(WW'(drv), WW'(0), "R6 write after read");
    step(1'b0, 1'b1, '1, 5, pat(2));
    chk(rd, pat(1), "R3 read other address");
    step(1'b0, 1'b1, '1, 6, '0);
    chk(rd, pat(2), "R4 write data taken next edge");
  endtask

  task automatic t_lanes;
    logic [WW-1:0] l1;
    l1 = WW'(36'h0_0003_FE00);
    step(1'b0, 1'b0, '0, 7, '0);
    step(1'b0, 1'b0, 4'b1101, 7, pat(3));
    step(1'b0, 1'b1, '1, 7, pat(4));
    chk(rd, (pat(3) & ~l1) | (pat(4) & l1), "R5 lane 1 only merged");
    step(1'b0, 1'b0, 4'b1111, 7, '0);
    step(1'b0, 1'b1, '1, 7, pat(5));
    chk(rd, (pat(3) & ~l1) | (pat(4) & l1), "R5 no lanes leaves word");
    desel('0);
  endtask

  task automatic t_desel;
    prefill(9, 1, 10);
    for (int v = 0; v < 3; v++) begin
      step_ce(1'b0, v == 0, v != 1, v == 2, 1'b0, 1'b0, '0, 9, '0);
      chk(WW'(drv), WW'(0), "R2 deselected write no drive");
      step(1'b0, 1'b1, '1, 9, pat(50 + v));
      chk(rd, pat(10), "R2 deselected write dropped");
    end
    step_ce(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '1, 9, '0);
    chk(WW'(drv), WW'(0), "R2 deselected read no drive");
  endtask

  task automatic t_pending_desel;
    step(1'b0, 1'b0, '0, 11, '0);
    desel(pat(11));
    chk(WW'(drv), WW'(0), "R6 deselect no drive");
    step(1'b0, 1'b1, '1, 11, '0);
    chk(rd, pat(11), "R12 pending write completes on deselect");
  endtask

  task automatic t_oe;
    step(1'b0, 1'b1, '1, 5, '0);
    oe_n = 1'b1; #1;
    chk(WW'(drv), WW'(0), "R7 oe high drive off");
    chk(rd, '0, "R7 oe high rdata zero");
    oe_n = 1'b0; #1;
    chk(rd, pat(1), "R7 oe low restores");
  endtask

  task automatic t_stall;
    step(1'b0, 1'b1, '1, 6, '0);
    step_ce(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, 5, '0);
    chk(rd, pat(2), "R8 stall holds read data");
    chk(WW'(drv), WW'(1), "R8 stall does not deselect");
    step(1'b0, 1'b0, '0, 13, '0);
    step_ce(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 13, pat(60));
    chk(WW'(drv), WW'(0), "R8 stall holds write");
    step(1'b0, 1'b1, '1, 13, pat(13));
    chk(rd, pat(13), "R8 write data after stall");
  endtask

  task automatic t_burst_lin;
    int exp_l[4] = '{21, 22, 23, 20};
    prefill(20, 4, 20);
    ilv = 1'b0;
    step(1'b0, 1'b1, '1, 21, '0);
    chk(rd, pat(exp_l[0]), "R9 linear beat 0");
    for (int n = 1; n < 4; n++) begin
      step(1'b1, 1'b1, '1, 0, '0);
      chk(rd, pat(exp_l[n]), "R9 linear beat");
    end
    step(1'b1, 1'b1, '1, 0, '0);
    chk(rd, pat(21), "R9 linear wrap");
  endtask

  task automatic t_burst_ilv;
    int exp_i[4] = '{21, 20, 23, 22};
    ilv = 1'b1;
    step(1'b0, 1'b1, '1, 21, '0);
    chk(rd, pat(exp_i[0]), "R10 interleaved beat 0");
    for (int n = 1; n < 4; n++) begin
      step(1'b1, 1'b1, '1, 0, '0);
      chk(rd, pat(exp_i[n]), "R10 interleaved beat");
    end
    ilv = 1'b0;
  endtask

  task automatic t_burst_wr;
    int order[4] = '{26, 27, 24, 25};
    step(1'b0, 1'b0, '0, 26, '0);
    step(1'b1, 1'b1, '0, 0, pat(100));
    chk(WW'(drv), WW'(0), "R11 advance keeps write despite we high");
    step(1'b1, 1'b0, '0, 0, pat(101));
    step(1'b1, 1'b1, '0, 0, pat(102));
    step(1'b0, 1'b1, '1, 26, pat(103));
    chk(rd, pat(100), "R11 write burst beat 0");
    for (int n = 1; n < 4; n++) begin
      step(1'b1, 1'b0, '1, 0, '0);
      chk(rd, pat(100 + n), $sformatf("R11 write burst beat addr %0d", order[n]));
    end
  endtask

  task automatic t_stop;
    desel('0);
    step(1'b1, 1'b1, '1, 0, '0);
    chk(WW'(drv), WW'(0), "R11 advance while idle");
    step(1'b0, 1'b1, '1, 21, '0);
    chk(rd, pat(21), "R12 burst start");
    desel('0);
    step(1'b1, 1'b1, '1, 0, '0);
    chk(WW'(drv), WW'(0), "R12 burst stopped by deselect");
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_back2back();
    t_lanes();
    t_desel();
    t_pending_desel();
    t_oe();
    t_stall();
    t_burst_lin();
    t_burst_ilv();
    t_burst_wr();
    t_stop();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule